// File: doc/BRIEF.md
# Floating-Point Normalize Unit

This unit takes a floating-point operand that has not been normalized and returns it in normalized form, along with a set of condition flags. The operand has two parts: an 8-bit two's-complement exponent, and a 32-bit two's-complement mantissa. Bit 31 of the mantissa is the sign. Bits 30..0 are the fraction. The implied bit sits between the sign and the fraction. On input, the implied bit is taken to be a copy of the sign, so the incoming value is treated as unnormalized.

The unit shifts the mantissa left until the bit just below the sign differs from the sign. It then lowers the exponent by the number of positions shifted and removes the implied bit from the stored result. Zero operands and results that fall below the exponent range become the reserved zero pattern: exponent -128 and mantissa 0.

The result and the flags are registered. They appear one clock after an input strobe, with a valid strobe of their own. A flag-write enable tells the surrounding pipeline whether the flags may be committed. It is set only when the destination is one of the extended-precision registers.

Top module: `fpnorm_unit`

## Requirements
- R1: For a positive non-zero mantissa m with exponent e not equal to -128, let k be the number of consecutive bits equal to bit 31, counting from bit 31 downward. Provided e-k >= -127, the result is out_exp = e-k and out_man = {0, (m << k)[30:0]}, with Z=0 and UF=0.
- R2: For a negative mantissa other than all-ones, the same rule as R1 applies, with out_man bit 31 equal to 1.
- R3: For the all-ones mantissa 0xFFFFFFFF, the shift is 32 and the result is out_man = 0x80000000 with out_exp = e-32, provided e-32 >= -127.
- R4: An input exponent of -128 (0x80) with mantissa 0 gives out_exp = 0x80 and out_man = 0, with Z=1 and UF=0.
- R5: An input exponent of -128 with a non-zero mantissa gives out_exp = 0x80 and out_man = 0, with Z=0 and UF=1.
- R6: A zero mantissa with any other exponent gives out_exp = 0x80 and out_man = 0, with Z=1 and UF=0.
- R7: When e-k < -127, the result is forced to out_exp = 0x80 and out_man = 0, with UF=1 and Z=1. A result exponent of exactly -127 is not an underflow.
- R8: N is 1 exactly when the result is non-zero and its bit 31 is 1. V is always 0.
- R9: LUF is 1 whenever UF is 1. Otherwise LUF equals the luf_prev input sampled with the operand.
- R10: out_valid is in_valid delayed by one clock. flag_we is 1 only in a valid output cycle whose operand arrived with dst_ext_reg = 1.
- R11: While reset is active and until the first strobe, out_valid and flag_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| dst_ext_reg | input | 1 | Destination is an extended-precision register |
| luf_prev | input | 1 | Current sticky underflow flag |
| in_exp | input | 8 | Operand exponent, two's complement |
| in_man | input | 32 | Operand mantissa, two's complement |
| out_valid | output | 1 | Result strobe |
| out_exp | output | 8 | Result exponent |
| out_man | output | 32 | Result mantissa, implied bit removed |
| flag_we | output | 1 | Flag write enable |
| flag_n | output | 1 | Negative result |
| flag_z | output | 1 | Zero result |
| flag_v | output | 1 | Overflow (always 0) |
| flag_uf | output | 1 | Underflow |
| flag_luf | output | 1 | Sticky underflow |

## Verification
The bench applies positive mantissas with shift counts of 1, 3 and 31. This shows whether the leading-sign count is taken from the right bit and whether the fraction is shifted by the same amount. Negative mantissas, including 0x80000000 and patterns with long runs of ones, show whether the search looks for the first bit that differs from the sign rather than the first 1. The all-ones mantissa exercises the 32-position shift. A sweep of exponents around the lower bound (results of -127 and -128) separates a correct underflow threshold from an off-by-one one. The three kinds of zero operand each have their own Z/UF pattern, and the bench tells them apart.

// File: rtl/fpnorm_pkg.sv
package fpnorm_pkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 32;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic uf;
    logic luf;
  } fpn_flags_t;
endpackage

// File: rtl/fpnorm_lsd.sv
// Leading-sign detector: counts bits equal to the sign from the MSB down.
module fpnorm_lsd #(
  parameter int MAN_W = fpnorm_pkg::MAN_W,
  parameter int CNT_W = $clog2(MAN_W + 1)
) (
  input  logic [MAN_W-1:0] man,
  output logic [CNT_W-1:0] cnt
);
  logic [MAN_W-2:0] diff;

  generate
    for (genvar i = 0; i < MAN_W - 1; i++) begin : g_diff
      assign diff[i] = man[i] ^ man[MAN_W-1];
    end
  endgenerate

  always_comb begin
    logic found;
    found = 1'b0;
    cnt   = CNT_W'(MAN_W);
    for (int i = MAN_W - 2; i >= 0; i--) begin
      if (!found && diff[i]) begin
        cnt   = CNT_W'(MAN_W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpnorm_shift.sv
// Fraction shifter and exponent adjust (exponent widened by two bits).
module fpnorm_shift #(
  parameter int EXP_W = fpnorm_pkg::EXP_W,
  parameter int MAN_W = fpnorm_pkg::MAN_W,
  parameter int CNT_W = $clog2(MAN_W + 1)
) (
  input  logic [MAN_W-2:0]        frac_in,
  input  logic [EXP_W-1:0]        exp_in,
  input  logic [CNT_W-1:0]        cnt,
  output logic [MAN_W-2:0]        frac_out,
  output logic signed [EXP_W+1:0] exp_out
);
  localparam int PAD_W = EXP_W + 2 - CNT_W;

  logic signed [EXP_W+1:0] exp_wide;
  logic signed [EXP_W+1:0] cnt_wide;

  always_comb begin
    frac_out = frac_in << cnt;
    exp_wide = $signed({{2{exp_in[EXP_W-1]}}, exp_in});
    cnt_wide = $signed({{PAD_W{1'b0}}, cnt});
    exp_out  = exp_wide - cnt_wide;
  end
endmodule

// File: rtl/fpnorm_unit.sv
module fpnorm_unit #(
  parameter int EXP_W = fpnorm_pkg::EXP_W,
  parameter int MAN_W = fpnorm_pkg::MAN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             dst_ext_reg,
  input  logic             luf_prev,
  input  logic [EXP_W-1:0] in_exp,
  input  logic [MAN_W-1:0] in_man,
  output logic             out_valid,
  output logic [EXP_W-1:0] out_exp,
  output logic [MAN_W-1:0] out_man,
  output logic             flag_we,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_uf,
  output logic             flag_luf
);
  import fpnorm_pkg::*;

  localparam int CNT_W = $clog2(MAN_W + 1);
  localparam logic [EXP_W-1:0] EXP_ZERO = {1'b1, {(EXP_W-1){1'b0}}};
  localparam logic signed [EXP_W+1:0] EXP_LOW =
    (EXP_W+2)'(1 - (2 ** (EXP_W - 1)));

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // Datapath
  logic [CNT_W-1:0]        shift_cnt;
  logic [MAN_W-2:0]        frac_norm;
  logic signed [EXP_W+1:0] exp_adj;

  fpnorm_lsd #(.MAN_W(MAN_W), .CNT_W(CNT_W)) u_lsd (
    .man (in_man),
    .cnt (shift_cnt)
  );

  fpnorm_shift #(.EXP_W(EXP_W), .MAN_W(MAN_W), .CNT_W(CNT_W)) u_shift (
    .frac_in  (in_man[MAN_W-2:0]),
    .exp_in   (in_exp),
    .cnt      (shift_cnt),
    .frac_out (frac_norm),
    .exp_out  (exp_adj)
  );

  // Next-state logic
  logic [EXP_W-1:0] exp_d;
  logic [MAN_W-1:0] man_d;
  fpn_flags_t       flags_d;
  logic             man_is_zero, exp_is_marker, exp_under;

  always_comb begin
    man_is_zero   = (in_man == '0);
    exp_is_marker = (in_exp == EXP_ZERO);
    exp_under     = (exp_adj < EXP_LOW);
    exp_d         = EXP_ZERO;
    man_d         = '0;
    flags_d       = '0;
    if (exp_is_marker) begin
      flags_d.z  = man_is_zero;
      flags_d.uf = !man_is_zero;
    end else if (man_is_zero) begin
      flags_d.z  = 1'b1;
    end else if (exp_under) begin
      flags_d.z  = 1'b1;
      flags_d.uf = 1'b1;
    end else begin
      exp_d      = exp_adj[EXP_W-1:0];
      man_d      = {in_man[MAN_W-1], frac_norm};
      flags_d.n  = in_man[MAN_W-1];
    end
    flags_d.luf = flags_d.uf | luf_prev;
  end

  // Registers
  logic             valid_q, we_q;
  logic [EXP_W-1:0] exp_q;
  logic [MAN_W-1:0] man_q;
  fpn_flags_t       flags_q;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      valid_q <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      valid_q <= in_valid;
      we_q    <= in_valid & dst_ext_reg;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      exp_q   <= '0;
      man_q   <= '0;
      flags_q <= '0;
    end else if (in_valid) begin
      exp_q   <= exp_d;
      man_q   <= man_d;
      flags_q <= flags_d;
    end
  end

  assign out_valid = valid_q;
  assign flag_we   = we_q;
  assign out_exp   = exp_q;
  assign out_man   = man_q;
  assign flag_n    = flags_q.n;
  assign flag_z    = flags_q.z;
  assign flag_v    = flags_q.v;
  assign flag_uf   = flags_q.uf;
  assign flag_luf  = flags_q.luf;
endmodule

// File: rtl/fpnorm_chk.sv
module fpnorm_chk #(
  parameter int EXP_W = fpnorm_pkg::EXP_W,
  parameter int MAN_W = fpnorm_pkg::MAN_W
) (
  input logic             clk,
  input logic             rst_q,
  input logic             in_valid,
  input logic             dst_ext_reg,
  input logic             luf_prev,
  input logic             out_valid,
  input logic [EXP_W-1:0] out_exp,
  input logic [MAN_W-1:0] out_man,
  input logic             flag_we,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_v,
  input logic             flag_uf,
  input logic             flag_luf
);
  localparam logic [EXP_W-1:0] EXP_ZERO = {1'b1, {(EXP_W-1){1'b0}}};

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> $past(in_valid));

  assert_we_gated_R10: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> (flag_we == $past(dst_ext_reg)));

  assert_we_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_q)
    flag_we |-> out_valid);

  assert_zero_pattern_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && flag_z) |-> (out_exp == EXP_ZERO && out_man == '0));

  assert_uf_result_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && flag_uf) |-> (out_exp == EXP_ZERO && out_man == '0 && flag_luf));

  assert_marker_exp_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && out_exp == EXP_ZERO) |-> (out_man == '0));

  assert_luf_hold_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !flag_uf) |-> (flag_luf == $past(luf_prev)));

  assert_neg_sign_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && flag_n) |-> (out_man[MAN_W-1] && !flag_z && !flag_v));
endmodule

bind fpnorm_unit fpnorm_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk         (clk),
  .rst_q       (rst_sync),
  .in_valid    (in_valid),
  .dst_ext_reg (dst_ext_reg),
  .luf_prev    (luf_prev),
  .out_valid   (out_valid),
  .out_exp     (out_exp),
  .out_man     (out_man),
  .flag_we     (flag_we),
  .flag_n      (flag_n),
  .flag_z      (flag_z),
  .flag_v      (flag_v),
  .flag_uf     (flag_uf),
  .flag_luf    (flag_luf)
);

// File: tb/tb_fpnorm_unit.sv
`timescale 1ns/1ps
module tb_fpnorm_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, dst_ext_reg, luf_prev;
  logic [7:0]  in_exp;
  logic [31:0] in_man;
  logic        out_valid, flag_we, flag_n, flag_z, flag_v, flag_uf, flag_luf;
  logic [7:0]  out_exp;
  logic [31:0] out_man;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  fpnorm_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_ext_reg(dst_ext_reg),
    .luf_prev(luf_prev), .in_exp(in_exp), .in_man(in_man),
    .out_valid(out_valid), .out_exp(out_exp), .out_man(out_man),
    .flag_we(flag_we), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_uf(flag_uf), .flag_luf(flag_luf)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Reference: shift a sign-extended copy until the two top bits differ
  task automatic ref_norm(input logic [7:0] e, input logic [31:0] m, input logic lp,
                          output logic [7:0] xe, output logic [31:0] xm,
                          output logic xn, output logic xz, output logic xuf,
                          output logic xluf);
    logic [32:0] w;
    int k, ne;
    w = {m[31], m};
    k = 0;
    while (k < 32 && w[32] == w[31]) begin
      w = w << 1;
      k++;
    end
    ne = int'($signed(e)) - k;
    xe = 8'h80; xm = '0; xn = 1'b0; xz = 1'b0; xuf = 1'b0;
    if (e == 8'h80) begin
      xz  = (m == 0);
      xuf = (m != 0);
    end else if (m == 0) begin
      xz = 1'b1;
    end else if (ne < -127) begin
      xz = 1'b1; xuf = 1'b1;
    end else begin
      xe = 8'(ne);
      xm = {w[32], w[30:0]};
      xn = w[32];
    end
    xluf = xuf | lp;
  endtask

  task automatic apply(input string tag, input logic [7:0] e, input logic [31:0] m,
                       input logic dst, input logic lp);
    logic [7:0] xe; logic [31:0] xm; logic xn, xz, xuf, xluf;
    ref_norm(e, m, lp, xe, xm, xn, xz, xuf, xluf);
    @(negedge clk);
    in_valid = 1'b1; dst_ext_reg = dst; luf_prev = lp; in_exp = e; in_man = m;
    @(negedge clk);
    in_valid = 1'b0; dst_ext_reg = 1'b0; luf_prev = 1'b0;
    chk("R10", "out_valid", 32'(out_valid), 32'd1);
    chk(tag, "out_exp", 32'(out_exp), 32'(xe));
    chk(tag, "out_man", out_man, xm);
    chk(tag, "flag_z", 32'(flag_z), 32'(xz));
    chk(tag, "flag_uf", 32'(flag_uf), 32'(xuf));
    chk("R8", "flag_n", 32'(flag_n), 32'(xn));
    chk("R8", "flag_v", 32'(flag_v), 32'd0);
    chk("R9", "flag_luf", 32'(flag_luf), 32'(xluf));
    chk("R10", "flag_we", 32'(flag_we), 32'(dst));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; dst_ext_reg = 1'b0; luf_prev = 1'b0;
    in_exp = '0; in_man = '0;
    repeat (3) @(negedge clk);
    chk("R11", "out_valid in reset", 32'(out_valid), 32'd0);
    chk("R11", "flag_we in reset", 32'(flag_we), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "out_valid after reset", 32'(out_valid), 32'd0);
    chk("R11", "flag_we after reset", 32'(flag_we), 32'd0);
  endtask

  task automatic t_positive();
    apply("R1", 8'd0,   32'h4000_0000, 1'b1, 1'b0); // k=1
    apply("R1", 8'd50,  32'h0000_0001, 1'b1, 1'b0); // k=31
    apply("R1", 8'hFD,  32'h1234_5678, 1'b1, 1'b0); // k=3
    apply("R1", 8'd127, 32'h7FFF_FFFF, 1'b1, 1'b0);
    apply("R1", 8'd10,  32'h0F0F_0F0F, 1'b1, 1'b0);
  endtask

  task automatic t_negative();
    apply("R2", 8'd0,   32'h8000_0000, 1'b1, 1'b0);
    apply("R2", 8'd20,  32'hFFFF_0000, 1'b1, 1'b0);
    apply("R2", 8'hF0,  32'hC000_0001, 1'b1, 1'b0);
    apply("R2", 8'd3,   32'hFFFF_FFFE, 1'b1, 1'b0);
    apply("R2", 8'd100, 32'hBFFF_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_all_ones();
    apply("R3", 8'd5,  32'hFFFF_FFFF, 1'b1, 1'b0); // exp -27
    apply("R3", 8'hA1, 32'hFFFF_FFFF, 1'b1, 1'b0); // -95-32 = -127
  endtask

  task automatic t_marker();
    apply("R4", 8'h80, 32'h0000_0000, 1'b1, 1'b0);
    apply("R5", 8'h80, 32'h1234_0000, 1'b1, 1'b0);
    apply("R5", 8'h80, 32'hFFFF_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_zero_man();
    apply("R6", 8'd7,  32'h0000_0000, 1'b1, 1'b0);
    apply("R6", 8'h81, 32'h0000_0000, 1'b1, 1'b1);
  endtask

  task automatic t_underflow();
    apply("R7", 8'hA0, 32'hFFFF_FFFF, 1'b1, 1'b0); // -96-32 = -128
    apply("R7", 8'h9C, 32'h0000_0001, 1'b1, 1'b0); // -100-31
    apply("R7", 8'hA0, 32'h0000_0001, 1'b1, 1'b0); // -96-31 = -127, no uf
    apply("R7", 8'h81, 32'h4000_0000, 1'b1, 1'b0); // -127-1 = -128
    apply("R7", 8'h82, 32'h4000_0000, 1'b1, 1'b0); // -126-1 = -127
  endtask

  task automatic t_luf();
    apply("R9", 8'd1,  32'h2000_0000, 1'b1, 1'b1); // held 1
    apply("R9", 8'd1,  32'h2000_0000, 1'b1, 1'b0); // held 0
    apply("R9", 8'h81, 32'h0000_0010, 1'b1, 1'b0); // set by uf
  endtask

  task automatic t_we();
    apply("R10", 8'd4, 32'h0100_0000, 1'b0, 1'b0);
    @(negedge clk);
    chk("R10", "out_valid idle", 32'(out_valid), 32'd0);
    chk("R10", "flag_we idle", 32'(flag_we), 32'd0);
    apply("R10", 8'd4, 32'hFE00_0000, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_positive();
    t_negative();
    t_all_ones();
    t_marker();
    t_zero_man();
    t_underflow();
    t_luf();
    t_we();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule